// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block talks to an 8-bit asynchronous NAND flash device for a simple host. The host picks one of two operations, device reset or single-page read, and gives a start pulse together with a 32-bit byte address. The block then runs the whole flash sequence by itself. It drives chip enable, the command and address latch strobes, write-enable and read-enable, and it drives the shared bidirectional data bus only while it is writing. It waits on the synchronized ready/busy line and streams the page out over a valid/ready byte interface.

The strobe timing comes from four small cycle counts supplied by the host. After each command that makes the device busy, the block waits a fixed settle window and then polls ready. A slow byte consumer stalls the read-enable pulses, and no byte is lost or repeated.

Top module: `nand_page_reader`

## Requirements
- R1: During a write cycle the block drives the bus. CLE is high for a command byte and ALE is high for an address byte, never both at once. Both stay low during read-enable pulses, and the bus is released while read-enable is low.
- R2: A page read writes command 0x00, then exactly four address bytes, then command 0x30, and then waits for ready before the first read-enable pulse.
- R3: The four address bytes carry address bits [7:0], [16:9], [24:17] and {0, [31:25]}, in that order. Bit 8 is never sent.
- R4: A page read produces exactly 512 read-enable pulses and 512 stream bytes, in bus order, each byte exactly once. While a byte is waiting for the consumer, rd_data_o stays stable and read-enable stays high.
- R5: A reset operation writes the single command 0xFF, waits for ready and completes with no read-enable pulse.
- R6: Chip enable (active low) goes low when an operation starts and stays low through all of its cycles. It rises exactly once, when the operation ends, and it is high while idle.
- R7: The ready/busy input passes through a two-flop synchronizer shown on ready_stat_o (1 = ready). No read-enable pulse starts while that bit reads busy, and ready is sampled only after a fixed settle window following 0x30 or 0xFF.
- R8: Write-enable low lasts max(we_low_cyc_i,1) clocks, and high lasts max(we_high_cyc_i,1) clocks between consecutive writes. Read-enable low lasts max(re_low_cyc_i,1) clocks. The high time between reads is at least max(re_high_cyc_i,1), and exactly that when the consumer is always ready.
- R9: busy_o is high from the clock after a start pulse until the operation ends. done_o pulses for one clock with busy_o low. A start pulse while busy is ignored.
- R10: After reset the block is idle, with chip enable, write-enable and read-enable high, CLE, ALE, busy_o, done_o and rd_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock start pulse |
| op_read_i | input | 1 | 1 = page read, 0 = device reset |
| addr_i | input | 32 | Byte address for a page read |
| we_low_cyc_i | input | 4 | Write-enable low width in clocks (0 acts as 1) |
| we_high_cyc_i | input | 4 | Write-enable high width in clocks (0 acts as 1) |
| re_low_cyc_i | input | 4 | Read-enable low width in clocks (0 acts as 1) |
| re_high_cyc_i | input | 4 | Minimum read-enable high width (0 acts as 1) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock end-of-operation pulse |
| ready_stat_o | output | 1 | Synchronized device ready (1) / busy (0) |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_cle_o | output | 1 | Command latch enable |
| flash_ale_o | output | 1 | Address latch enable |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_re_n_o | output | 1 | Read enable, active low |
| flash_dq_io | inout | 8 | Shared command/address/data bus |
| flash_rb_i | input | 1 | Device ready/busy, 1 = ready |
| rd_data_o | output | 8 | Stream byte |
| rd_valid_o | output | 1 | Stream byte valid |
| rd_ready_i | input | 1 | Stream consumer ready |

## Verification
On every cycle the assertions check the mutual exclusion of CLE and ALE, the bus release under read-enable, chip enable held under any strobe, the stream byte held stable under back-pressure, the byte count bound, and the shape of the done pulse against busy. Only the bench scenarios can show the full command and address order with its bit mapping, the exact strobe widths across a sweep of cycle counts, the 512-byte content in order under back-pressure, the absence of reads before the device reports ready, and that a stray start pulse leaves a running read untouched.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WE_LO,
        PH_WE_HI,
        PH_SETTLE,
        PH_WAIT_RB,
        PH_RE_LO,
        PH_RE_HI
    } phase_e;

    typedef enum logic [1:0] {
        STEP_OPEN,
        STEP_ADDR,
        STEP_CONFIRM,
        STEP_DEVRST
    } step_e;

    localparam logic [7:0] CMD_OPEN    = 8'h00;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;
    localparam logic [7:0] CMD_DEVRST  = 8'hFF;

endpackage

// File: rtl/nandrd_rb_sync.sv
module nandrd_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_i,
    output logic rb_sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], rb_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rb_sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/nandrd_phase_timer.sv
module nandrd_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    // A length of zero behaves as one clock.
    always_comb begin
        if (load_i)
            cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/nandrd_addr_slicer.sv
module nandrd_addr_slicer #(
    parameter int CYCLES = 4,
    localparam int IDX_W = (CYCLES > 1) ? $clog2(CYCLES) : 1,
    localparam int EXT_W = 8 * CYCLES + 8
) (
    input  logic [31:0]      addr_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    logic [EXT_W-1:0] ext;
    logic [7:0]       lane [CYCLES];

    assign ext = {{(EXT_W-32){1'b0}}, addr_i};

    // Lane 0 takes bits [7:0]; each later lane starts one bit past the
    // previous lane's end plus one skipped bit for lane 1 (bit 8 unused).
    for (genvar k = 0; k < CYCLES; k++) begin : g_lane
        localparam int SH = (k == 0) ? 0 : (9 + 8 * (k - 1));
        assign lane[k] = ext[SH +: 8];
    end

    assign byte_o = lane[idx_i];
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
    parameter int PAGE_BYTES    = 512,
    parameter int ADDR_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 6,
    parameter int SYNC_STAGES   = 2,
    parameter int CFG_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_read_i,
    input  logic [31:0]      addr_i,
    input  logic [CFG_W-1:0] we_low_cyc_i,
    input  logic [CFG_W-1:0] we_high_cyc_i,
    input  logic [CFG_W-1:0] re_low_cyc_i,
    input  logic [CFG_W-1:0] re_high_cyc_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ready_stat_o,
    output logic             flash_ce_n_o,
    output logic             flash_cle_o,
    output logic             flash_ale_o,
    output logic             flash_we_n_o,
    output logic             flash_re_n_o,
    inout  wire  [7:0]       flash_dq_io,
    input  logic             flash_rb_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i
);
    import nandrd_pkg::*;

    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam int IDX_W = (ADDR_CYCLES > 1) ? $clog2(ADDR_CYCLES) : 1;
    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
    localparam int TW    = (SET_W > CFG_W) ? SET_W : CFG_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        phase_e           phase;
        step_e            step;
        logic             is_read;
        logic [31:0]      addr;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] nbytes;
        logic [7:0]       rdata;
        logic             rvalid;
        logic             done;
        logic             ce_n;
        logic             cle;
        logic             ale;
        logic             we_n;
        logic             re_n;
        logic             oe;
    } regs_t;

    regs_t r_d, r_q;

    logic          rb_sync;
    logic          tmr_load;
    logic [TW-1:0] tmr_len;
    logic          tmr_exp;
    logic [7:0]    addr_byte;
    logic [7:0]    wbyte;

    nandrd_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rb_i      (flash_rb_i),
        .rb_sync_o (rb_sync)
    );

    nandrd_phase_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_exp)
    );

    nandrd_addr_slicer #(.CYCLES(ADDR_CYCLES)) u_slice (
        .addr_i (r_q.addr),
        .idx_i  (r_q.idx),
        .byte_o (addr_byte)
    );

    // Byte on the bus follows the registered step, stable through both WE phases.
    always_comb begin
        unique case (r_q.step)
            STEP_OPEN:    wbyte = CMD_OPEN;
            STEP_ADDR:    wbyte = addr_byte;
            STEP_CONFIRM: wbyte = CMD_CONFIRM;
            default:      wbyte = CMD_DEVRST;
        endcase
    end

    assign flash_dq_io = r_q.oe ? wbyte : 8'hzz;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        if (r_q.rvalid && rd_ready_i)
            r_d.rvalid = 1'b0;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.is_read = op_read_i;
                    r_d.addr    = addr_i;
                    r_d.idx     = '0;
                    r_d.nbytes  = '0;
                    r_d.step    = op_read_i ? STEP_OPEN : STEP_DEVRST;
                    r_d.phase   = PH_WE_LO;
                end
            end
            PH_WE_LO: begin
                if (tmr_exp) r_d.phase = PH_WE_HI;
            end
            PH_WE_HI: begin
                if (tmr_exp) begin
                    unique case (r_q.step)
                        STEP_OPEN: begin
                            r_d.step  = STEP_ADDR;
                            r_d.idx   = '0;
                            r_d.phase = PH_WE_LO;
                        end
                        STEP_ADDR: begin
                            if (r_q.idx == LAST_IDX) r_d.step = STEP_CONFIRM;
                            else                     r_d.idx  = r_q.idx + 1'b1;
                            r_d.phase = PH_WE_LO;
                        end
                        default: r_d.phase = PH_SETTLE;
                    endcase
                end
            end
            PH_SETTLE: begin
                if (tmr_exp) r_d.phase = PH_WAIT_RB;
            end
            PH_WAIT_RB: begin
                if (rb_sync) begin
                    if (r_q.is_read) begin
                        r_d.phase = PH_RE_LO;
                    end else begin
                        r_d.phase = PH_IDLE;
                        r_d.done  = 1'b1;
                    end
                end
            end
            PH_RE_LO: begin
                if (tmr_exp) begin
                    r_d.rdata  = flash_dq_io;
                    r_d.rvalid = 1'b1;
                    r_d.nbytes = r_q.nbytes + 1'b1;
                    r_d.phase  = PH_RE_HI;
                end
            end
            PH_RE_HI: begin
                if (tmr_exp && !r_d.rvalid) begin
                    if (r_q.nbytes == PAGE_CNT) begin
                        r_d.phase = PH_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.phase = PH_RE_LO;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase

        // Pin levels are registered from the next phase.
        r_d.ce_n = (r_d.phase == PH_IDLE);
        r_d.we_n = (r_d.phase != PH_WE_LO);
        r_d.re_n = (r_d.phase != PH_RE_LO);
        r_d.oe   = (r_d.phase == PH_WE_LO) || (r_d.phase == PH_WE_HI);
        r_d.cle  = r_d.oe && (r_d.step != STEP_ADDR);
        r_d.ale  = r_d.oe && (r_d.step == STEP_ADDR);

        tmr_load = (r_d.phase != r_q.phase);
        unique case (r_d.phase)
            PH_WE_LO:  tmr_len = TW'(we_low_cyc_i);
            PH_WE_HI:  tmr_len = TW'(we_high_cyc_i);
            PH_RE_LO:  tmr_len = TW'(re_low_cyc_i);
            PH_RE_HI:  tmr_len = TW'(re_high_cyc_i);
            PH_SETTLE: tmr_len = TW'(SETTLE_CYCLES);
            default:   tmr_len = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.phase  <= PH_IDLE;
            r_q.step   <= STEP_OPEN;
            r_q.ce_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.re_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.phase != PH_IDLE);
    assign done_o       = r_q.done;
    assign ready_stat_o = rb_sync;
    assign flash_ce_n_o = r_q.ce_n;
    assign flash_cle_o  = r_q.cle;
    assign flash_ale_o  = r_q.ale;
    assign flash_we_n_o = r_q.we_n;
    assign flash_re_n_o = r_q.re_n;
    assign rd_data_o    = r_q.rdata;
    assign rd_valid_o   = r_q.rvalid;

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(flash_cle_o && flash_ale_o)); // R1
    AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !flash_re_n_o |-> !r_q.oe && !flash_cle_o && !flash_ale_o); // R1
    AST_CE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!flash_we_n_o || !flash_re_n_o) |-> !flash_ce_n_o); // R6
    AST_FIRST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n) ($fell(flash_re_n_o) && $past(r_q.phase == PH_WAIT_RB)) |-> $past(rb_sync)); // R7
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(rd_data_o)); // R4
    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) r_q.nbytes <= PAGE_CNT); // R4
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o && $past(busy_o)); // R9
endmodule

// File: tb/nand_page_reader_test.sv
module nand_page_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_read = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  we_lo = 4'd1, we_hi = 4'd1, re_lo = 4'd1, re_hi = 4'd1;
    logic        rb = 1'b1;
    logic        m_ready = 1'b1;
    wire  [7:0]  dq;
    logic        busy, done, rstat, ce_n, cle, ale, we_n, re_n, m_valid;
    logic [7:0]  m_data;

    always #5 clk = ~clk;

    nand_page_reader uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_read_i(op_read), .addr_i(addr),
        .we_low_cyc_i(we_lo), .we_high_cyc_i(we_hi), .re_low_cyc_i(re_lo), .re_high_cyc_i(re_hi),
        .busy_o(busy), .done_o(done), .ready_stat_o(rstat),
        .flash_ce_n_o(ce_n), .flash_cle_o(cle), .flash_ale_o(ale),
        .flash_we_n_o(we_n), .flash_re_n_o(re_n), .flash_dq_io(dq), .flash_rb_i(rb),
        .rd_data_o(m_data), .rd_valid_o(m_valid), .rd_ready_i(m_ready)
    );

    int checks = 0, fails = 0, cyc = 0;

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        logic [7:0] r;
        r = 8'(i * 37) + seed;
        r = r ^ 8'(i >> 8);
        return r;
    endfunction

    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    function automatic logic [7:0] abyte(input logic [31:0] a, input int k);
        case (k)
            0:       return a[7:0];
            1:       return a[16:9];
            2:       return a[24:17];
            default: return {1'b0, a[31:25]};
        endcase
    endfunction

    // Device model and stream consumer state
    logic [7:0] mdl_seed = '0;
    int         mdl_idx = 0;
    logic [7:0] wr_byte [8];
    logic       wr_cle [8];
    logic       wr_ale [8];
    int wr_cnt, rd_cnt, rx_cnt, rx_err, rb_viol, width_err, ce_rises, ce_err, done_cnt, busy_left;
    int we_lo_run, we_hi_run, re_lo_run, re_hi_run;
    int exp_we_lo, exp_we_hi, exp_re_lo, exp_re_hi;
    logic strict_re = 1'b1, bp = 1'b0, saw_busy_stat = 1'b0;
    logic [7:0] exp_seed = '0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_ce = 1'b1;

    assign dq = !re_n ? pat(mdl_seed, mdl_idx) : 8'hzz;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (!we_n) begin
                if (prev_we) begin
                    if (wr_cnt > 0 && we_hi_run != exp_we_hi) width_err++;
                    we_lo_run = 1;
                end else we_lo_run++;
            end else begin
                if (!prev_we) begin
                    if (we_lo_run != exp_we_lo) width_err++;
                    if (wr_cnt < 8) begin
                        wr_byte[wr_cnt] = dq; wr_cle[wr_cnt] = cle; wr_ale[wr_cnt] = ale;
                    end
                    wr_cnt++;
                    if (cle && dq == 8'h00) begin mdl_seed = '0; mdl_idx = 0; end
                    if (ale) mdl_seed = mdl_seed ^ dq;
                    if (cle && (dq == 8'h30 || dq == 8'hFF)) begin busy_left = 20; rb = 1'b0; end
                    we_hi_run = 1;
                end else we_hi_run++;
            end
            if (!re_n) begin
                if (prev_re) begin
                    if (!rb) rb_viol++;
                    if (rd_cnt > 0 && (re_hi_run < exp_re_hi || (strict_re && re_hi_run != exp_re_hi))) width_err++;
                    re_lo_run = 1;
                end else re_lo_run++;
            end else begin
                if (!prev_re) begin
                    if (re_lo_run != exp_re_lo) width_err++;
                    rd_cnt++;
                    mdl_idx++;
                    re_hi_run = 1;
                end else re_hi_run++;
            end
            if (!prev_ce && ce_n) ce_rises++;
            if (busy && ce_n) ce_err++;
            if (done) done_cnt++;
            if (!rstat) saw_busy_stat = 1'b1;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) rb = 1'b1;
            end
            m_ready = bp ? ((cyc % 5) < 2) : 1'b1;
            if (m_valid && m_ready) begin
                if (m_data != pat(exp_seed, rx_cnt)) rx_err++;
                rx_cnt++;
            end
            prev_we = we_n; prev_re = re_n; prev_ce = ce_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        wr_cnt = 0; rd_cnt = 0; rx_cnt = 0; rx_err = 0; rb_viol = 0; width_err = 0;
        ce_rises = 0; ce_err = 0; done_cnt = 0; saw_busy_stat = 1'b0;
        exp_we_lo = eff(we_lo); exp_we_hi = eff(we_hi);
        exp_re_lo = eff(re_lo); exp_re_hi = eff(re_hi);
    endtask

    task automatic run_op(input logic rd, input logic [31:0] a, input logic use_bp, input logic inject);
        int n;
        bit timed_out;
        @(negedge clk);
        clear_model();
        bp = use_bp; strict_re = !use_bp;
        exp_seed = abyte(a, 0) ^ abyte(a, 1) ^ abyte(a, 2) ^ abyte(a, 3);
        start = 1'b1; op_read = rd; addr = a;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", int'(busy), 1);
        n = 0; timed_out = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (inject && n == 30) begin start = 1'b1; op_read = 1'b0; end
            else if (inject && n == 31) start = 1'b0;
            if (n > 60000) begin timed_out = 1; break; end
        end
        chk("R9 watchdog", int'(timed_out), 0);
        chk("R9 busy low at done", int'(busy), 0);
        chk("R6 ce high at done", int'(ce_n), 1);
        @(negedge clk);
        chk("R9 done one clock", int'(done), 0);
        chk("R9 single done", done_cnt, 1);
        chk("R6 one ce release", ce_rises, 1);
        chk("R6 ce low while busy", ce_err, 0);
        chk("R8 strobe widths", width_err, 0);
        chk("R7 status showed busy", int'(saw_busy_stat), 1);
        chk("R7 status ready at end", int'(rstat), 1);
        if (rd) begin
            chk("R2 write count", wr_cnt, 6);
            chk("R2 open cmd", int'(wr_byte[0]), 8'h00);
            chk("R1 open cle", int'({wr_cle[0], wr_ale[0]}), 2);
            for (int k = 0; k < 4; k++) begin
                chk("R3 address byte", int'(wr_byte[k+1]), int'(abyte(a, k)));
                chk("R1 address ale", int'({wr_cle[k+1], wr_ale[k+1]}), 1);
            end
            chk("R2 confirm cmd", int'(wr_byte[5]), 8'h30);
            chk("R1 confirm cle", int'({wr_cle[5], wr_ale[5]}), 2);
            chk("R7 no read while busy", rb_viol, 0);
            chk("R4 read pulses", rd_cnt, 512);
            chk("R4 stream bytes", rx_cnt, 512);
            chk("R4 stream content", rx_err, 0);
        end else begin
            chk("R5 write count", wr_cnt, 1);
            chk("R5 reset cmd", int'(wr_byte[0]), 8'hFF);
            chk("R5 reset cle", int'({wr_cle[0], wr_ale[0]}), 2);
            chk("R5 no reads", rd_cnt, 0);
            chk("R5 no stream", rx_cnt, 0);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R9 global watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ce_n", int'(ce_n), 1);
        chk("R10 we_n", int'(we_n), 1);
        chk("R10 re_n", int'(re_n), 1);
        chk("R10 cle/ale", int'({cle, ale}), 0);
        chk("R10 busy/done", int'({busy, done}), 0);
        chk("R10 valid", int'(m_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 status after sync", int'(rstat), 1);

        // R5/R8: reset operation over every write-enable low width
        for (int v = 0; v < 16; v++) begin
            we_lo = 4'(v); we_hi = 4'((v + 3) % 16);
            run_op(1'b0, 32'h0, 1'b0, 1'b0);
        end

        we_lo = 0; we_hi = 0; re_lo = 0; re_hi = 0;
        run_op(1'b1, 32'h1234_5678, 1'b0, 1'b0);
        we_lo = 1; we_hi = 2; re_lo = 1; re_hi = 1;
        run_op(1'b1, 32'h0000_0100, 1'b1, 1'b0);
        we_lo = 3; we_hi = 1; re_lo = 2; re_hi = 3;
        run_op(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);   // R9 start while busy ignored
        we_lo = 15; we_hi = 15; re_lo = 4; re_hi = 5;
        run_op(1'b1, 32'h0001_FEFF, 1'b1, 1'b0);
        we_lo = 2; we_hi = 0; re_lo = 0; re_hi = 2;
        run_op(1'b1, 32'h8000_0001, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule